// File: doc/BRIEF.md
# Programmable-Radix Nibble ALU

This block is the arithmetic and logic stage of a nibble-wide datapath. Each issued operation takes two 4-bit operands, a carry input, a 4-bit radix field and the current flag nibble. One clock later the block presents a 4-bit result, a write-enable that says whether the result must be stored, and the next value of the flag nibble. Operand fetch, memory access and instruction sequencing belong to the surrounding core.

Besides plain binary addition with or without carry, the adder can correct its sum to any radix from 1 to 16. The radix is given as a field holding 16 minus the radix, so field 0 selects radix 16 and field 15 selects radix 1. A carry-only variant forces the second operand to zero. This lets a base-n counter ripple a carry into its top digit. The logic side offers AND, a non-writing bit test, and an AND that clears chosen bits of the flag nibble.

The flag nibble packs four flags: bit 3 = E (extension), bit 2 = I (interrupt enable), bit 1 = C (carry), bit 0 = Z (zero).

Top module: `nibalu`

## Requirements
- R1: While rst_n is low and on the first cycle after it, res, wr_en and flags_out are all zero.
- R2: Opcode 0 (binary add) gives res = (a + b) mod 16 and C = carry out of bit 3. It ignores cin and sets wr_en = 1. Outputs appear on the clock edge after the issue cycle.
- R3: Opcode 1 (binary add with carry) gives res = (a + b + cin) mod 16 and C = carry out of bit 3, with wr_en = 1.
- R4: Opcode 2 (radix add with carry) uses radix n = 16 - radix_fld. It forms S = a + b + cin. If S >= n, res = (S - n) mod 16 and C = 1. Otherwise res = S and C = 0. It sets wr_en = 1.
- R5: With radix_fld = 0 (radix 16), opcode 2 gives the same res and C as opcode 1 for every operand pair.
- R6: Opcode 3 (radix carry ripple) behaves as opcode 2 with b taken as 0, whatever b holds. It sets wr_en = 1.
- R7: Opcodes 0 to 5 clear E and leave I equal to flags_in bit 2.
- R8: For opcodes 0 to 5, Z is 1 exactly when the final 4-bit result (after any radix correction) is zero.
- R9: Opcode 4 (AND) gives res = a & b, keeps C equal to flags_in bit 1, and sets wr_en = 1.
- R10: Opcode 5 (bit test) sets Z from a & b and keeps C. It drives wr_en = 0.
- R11: Opcode 6 (flag clear) gives flags_out = flags_in & b and res = flags_in & b. It drives wr_en = 0, so it can only clear flags, never set them.
- R12: A cycle with issue low, or opcode 7, gives wr_en = 0 and flags_out = flags_in on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | An operation is presented this cycle |
| op | input | 3 | Operation code (see requirements) |
| a | input | 4 | Destination-side operand |
| b | input | 4 | Source operand or immediate / flag mask |
| cin | input | 1 | Carry input for carry-consuming operations |
| radix_fld | input | 4 | 16 minus the radix for radix operations |
| flags_in | input | 4 | Current flags {E,I,C,Z} |
| res | output | 4 | Registered result |
| wr_en | output | 1 | Result must be written back |
| flags_out | output | 4 | Next flags {E,I,C,Z} |

## Verification
The bench targets the radix boundaries. A sum one below the radix must stay put, and a sum exactly equal to the radix must fold to zero with carry. It also covers radix 1, where any carry in wraps at once, and radix 16, which must match binary carry. A design that compared with greater-than instead of greater-or-equal would miss the fold. A design that decoded the field as the radix itself instead of 16 minus it would fold at the wrong point. A zero flag taken before correction would show up on an exact fold. The bench also checks that a bit test writes nothing, that the carry-only form ignores a live source operand, and that the flag-clear AND can never raise a flag.

// File: rtl/nibalu_pkg.sv
package nibalu_pkg;

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_ADC   = 3'd1,
    OP_RADC  = 3'd2,
    OP_RCRY  = 3'd3,
    OP_AND   = 3'd4,
    OP_TEST  = 3'd5,
    OP_FCLR  = 3'd6,
    OP_NOP   = 3'd7
  } op_e;

  typedef struct packed {
    logic e;
    logic i;
    logic c;
    logic z;
  } flags_t;

  // radix value from the field coding (2**w minus field), w+1 bits wide
  function automatic logic [4:0] radix_of(input logic [3:0] fld);
    return 5'd16 - {1'b0, fld};
  endfunction

  // unadjusted sum including carry, one bit wider than the operands
  function automatic logic [4:0] raw_sum(input logic [3:0] x, input logic [3:0] y,
                                         input logic c);
    return {1'b0, x} + {1'b0, y} + {4'd0, c};
  endfunction

  function automatic logic is_arith(input op_e o);
    return (o == OP_ADD) || (o == OP_ADC) || (o == OP_RADC) || (o == OP_RCRY);
  endfunction

endpackage

// File: rtl/nibalu_adder.sv
module nibalu_adder
  import nibalu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         c_in,
  input  logic         radix_en,
  input  logic [W-1:0] fld,
  output logic [W-1:0] sum,
  output logic         c_out,
  output logic         wrap,
  output logic [W:0]   sum_raw
);
  localparam int SW = W + 1;

  logic [SW-1:0] n_val;
  logic [SW-1:0] folded;

  always_comb begin
    sum_raw = raw_sum(x, y, c_in);
    n_val   = radix_of(fld);
    wrap    = radix_en && (sum_raw >= n_val);
    folded  = sum_raw - n_val;
    if (!radix_en) begin
      sum   = sum_raw[W-1:0];
      c_out = sum_raw[W];
    end else if (wrap) begin
      sum   = folded[W-1:0];
      c_out = 1'b1;
    end else begin
      sum   = sum_raw[W-1:0];
      c_out = 1'b0;
    end
  end

endmodule

// File: rtl/nibalu_logic.sv
module nibalu_logic #(
  parameter int W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] conj
);
  always_comb conj = x & y;
endmodule

// File: rtl/nibalu_flagunit.sv
module nibalu_flagunit
  import nibalu_pkg::*;
#(
  parameter int W = 4
) (
  input  op_e          op,
  input  logic         issue,
  input  flags_t       f_in,
  input  logic [3:0]   mask,
  input  logic         add_c,
  input  logic [W-1:0] result,
  output flags_t       f_nxt,
  output logic         zero_hit
);
  always_comb begin
    zero_hit = (result == '0);
    f_nxt    = f_in;
    if (issue) begin
      case (op)
        OP_ADD, OP_ADC, OP_RADC, OP_RCRY: begin
          f_nxt.e = 1'b0;
          f_nxt.c = add_c;
          f_nxt.z = zero_hit;
        end
        OP_AND, OP_TEST: begin
          f_nxt.e = 1'b0;
          f_nxt.z = zero_hit;
        end
        OP_FCLR: f_nxt = f_in & flags_t'(mask);
        default: f_nxt = f_in;
      endcase
    end
  end
endmodule

// File: rtl/nibalu.sv
module nibalu
  import nibalu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         issue,
  input  logic [2:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic [W-1:0] radix_fld,
  input  logic [3:0]   flags_in,
  output logic [W-1:0] res,
  output logic         wr_en,
  output logic [3:0]   flags_out
);
  op_e          op_q;
  logic [W-1:0] add_y;
  logic         add_cin;
  logic         add_radix;
  logic [W-1:0] add_sum;
  logic         add_cout;
  logic         adder_wrap;
  logic [W:0]   adder_raw;
  logic [W-1:0] and_res;
  logic [W-1:0] res_nxt;
  logic         we_nxt;
  logic         zero_hit;
  flags_t       f_nxt;

  assign op_q = op_e'(op);

  always_comb begin
    add_y     = (op_q == OP_RCRY) ? '0 : b;
    add_cin   = (op_q == OP_ADD) ? 1'b0 : cin;
    add_radix = (op_q == OP_RADC) || (op_q == OP_RCRY);
  end

  nibalu_adder #(.W(W)) u_add (
    .x(a), .y(add_y), .c_in(add_cin), .radix_en(add_radix), .fld(radix_fld),
    .sum(add_sum), .c_out(add_cout), .wrap(adder_wrap), .sum_raw(adder_raw)
  );

  nibalu_logic #(.W(W)) u_log (.x(a), .y(b), .conj(and_res));

  always_comb begin
    res_nxt = '0;
    we_nxt  = 1'b0;
    if (issue) begin
      if (is_arith(op_q)) begin
        res_nxt = add_sum;
        we_nxt  = 1'b1;
      end else if (op_q == OP_AND) begin
        res_nxt = and_res;
        we_nxt  = 1'b1;
      end else if (op_q == OP_TEST) begin
        res_nxt = and_res;
      end else if (op_q == OP_FCLR) begin
        res_nxt = W'(flags_in & b[3:0]);
      end
    end
  end

  nibalu_flagunit #(.W(W)) u_flg (
    .op(op_q), .issue(issue), .f_in(flags_t'(flags_in)), .mask(b[3:0]),
    .add_c(add_cout), .result(res_nxt), .f_nxt(f_nxt), .zero_hit(zero_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res       <= '0;
      wr_en     <= 1'b0;
      flags_out <= '0;
    end else begin
      res       <= res_nxt;
      wr_en     <= we_nxt;
      flags_out <= f_nxt;
    end
  end

endmodule

// File: rtl/nibalu_chk.sv
module nibalu_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         issue,
  input logic [2:0]   op,
  input logic [3:0]   flags_in,
  input logic [W-1:0] b,
  input logic [W-1:0] res,
  input logic         wr_en,
  input logic [3:0]   flags_out,
  input logic         adder_wrap,
  input logic         zero_hit
);
  logic alu_op;
  assign alu_op = issue && (op <= 3'd5);

  // R7
  a_r7_e_clear: assert property (@(posedge clk) disable iff (!rst_n)
    alu_op |=> !flags_out[3]);
  // R7
  a_r7_i_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && op != 3'd6) |=> flags_out[2] == $past(flags_in[2]));
  // R8
  a_r8_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    alu_op |=> flags_out[0] == (res == '0));
  // R8
  a_r8_zero_src: assert property (@(posedge clk) disable iff (!rst_n)
    alu_op |=> flags_out[0] == $past(zero_hit));
  // R4
  a_r4_wrap_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && (op == 3'd2 || op == 3'd3)) |=> flags_out[1] == $past(adder_wrap));
  // R9 R10
  a_r9_c_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && (op == 3'd4 || op == 3'd5)) |=> flags_out[1] == $past(flags_in[1]));
  // R10
  a_r10_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && op == 3'd5) |=> !wr_en);
  // R11
  a_r11_only_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && op == 3'd6) |=> ((flags_out & ~$past(flags_in)) == 4'd0) && !wr_en);
  // R12
  a_r12_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!issue || op == 3'd7) |=> !wr_en && flags_out == $past(flags_in));
endmodule

bind nibalu nibalu_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .issue(issue), .op(op), .flags_in(flags_in), .b(b),
  .res(res), .wr_en(wr_en), .flags_out(flags_out), .adder_wrap(adder_wrap),
  .zero_hit(zero_hit)
);

// File: tb/tb_nibalu.sv
`timescale 1ns/1ps
module tb_nibalu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       issue = 1'b0;
  logic [2:0] op = 3'd0;
  logic [3:0] a = 4'd0, b = 4'd0, radix_fld = 4'd0, flags_in = 4'd0;
  logic       cin = 1'b0;
  logic [3:0] res, flags_out;
  logic       wr_en;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  nibalu dut (
    .clk(clk), .rst_n(rst_n), .issue(issue), .op(op), .a(a), .b(b), .cin(cin),
    .radix_fld(radix_fld), .flags_in(flags_in), .res(res), .wr_en(wr_en),
    .flags_out(flags_out)
  );

  // behavioural model from the requirements
  task automatic model(input int o, input int x, input int y, input int c, input int fld,
                       input int fi, input bit iss,
                       output int r, output int we, output int fo);
    int s, n, cy, e, i, z;
    e = (fi >> 3) & 1; i = (fi >> 2) & 1; cy = (fi >> 1) & 1; z = fi & 1;
    r = 0; we = 0; fo = fi;
    if (!iss || o == 7) return;
    case (o)
      0, 1: begin
        s = x + y + ((o == 1) ? c : 0);
        r = s % 16; cy = s / 16; we = 1;
      end
      2, 3: begin
        n = 16 - fld;
        s = x + ((o == 3) ? 0 : y) + c;
        if (s >= n) begin r = (s - n) % 16; cy = 1; end
        else begin r = s; cy = 0; end
        we = 1;
      end
      4: begin r = x & y; we = 1; end
      5: begin r = x & y; we = 0; end
      default: begin r = fi & y; fo = fi & y; return; end
    endcase
    e = 0; z = (r == 0) ? 1 : 0;
    fo = e * 8 + i * 4 + cy * 2 + z;
  endtask

  function automatic string tag_of(input int o, input bit iss);
    if (!iss) return "R12";
    case (o)
      0: return "R2";  1: return "R3";  2: return "R4";  3: return "R6";
      4: return "R9";  5: return "R10"; 6: return "R11"; default: return "R12";
    endcase
  endfunction

  task automatic run(input int o, input int x, input int y, input int c, input int fld,
                     input int fi, input bit iss, input string tag);
    int er, ew, ef;
    op = o[2:0]; a = x[3:0]; b = y[3:0]; cin = c[0]; radix_fld = fld[3:0];
    flags_in = fi[3:0]; issue = iss;
    model(o, x, y, c, fld, fi, iss, er, ew, ef);
    @(posedge clk); #1;
    n_tests++;
    if (res != er[3:0] || wr_en != ew[0] || flags_out != ef[3:0]) begin
      n_fail++;
      $display("FAIL %s/R7/R8 op=%0d a=%0d b=%0d cin=%0d fld=%0d fi=%h: res=%0d we=%0d fl=%h expected res=%0d we=%0d fl=%h",
               tag, o, x, y, c, fld, fi, res, wr_en, flags_out, er, ew, ef);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int r3, f3;
    repeat (3) @(posedge clk);
    #1;
    n_tests++;
    if (res != 0 || wr_en != 0 || flags_out != 0) begin
      n_fail++;
      $display("FAIL R1 reset: res=%0d we=%0d fl=%h expected 0 0 0", res, wr_en, flags_out);
    end
    rst_n = 1'b1;
    // R2: binary add ignores cin, carry out and wrap to zero
    run(0, 9, 7, 1, 0, 4'hC, 1, "R2");
    run(0, 3, 4, 1, 0, 4'h0, 1, "R2");
    // R3: add with carry
    run(1, 15, 0, 1, 0, 4'h4, 1, "R3");
    run(1, 5, 6, 1, 0, 4'hA, 1, "R3");
    // R4: decimal radix (fld 6 -> n 10): 9+0+0 stays, 9+0+1 folds to 0, 9+9+1 -> 9
    run(2, 9, 0, 0, 6, 4'h0, 1, "R4");
    run(2, 9, 0, 1, 6, 4'h0, 1, "R4");
    run(2, 9, 9, 1, 6, 4'h8, 1, "R4");
    // R4: radix 1 (fld 15) wraps a lone carry at once
    run(2, 0, 0, 1, 15, 4'h0, 1, "R4");
    run(2, 0, 0, 0, 15, 4'h2, 1, "R4");
    // R5: radix 16 matches binary add with carry
    for (int k = 0; k < 40; k++) begin
      int x, y, c, er, ew, ef, br, bw, bf;
      x = $urandom_range(0, 15); y = $urandom_range(0, 15); c = $urandom_range(0, 1);
      model(1, x, y, c, 0, 0, 1, br, bw, bf);
      run(2, x, y, c, 0, 0, 1, "R5");
      n_tests++;
      if (res != br[3:0] || flags_out[1] != bf[1]) begin
        n_fail++;
        $display("FAIL R5 a=%0d b=%0d c=%0d: res=%0d C=%0d expected %0d %0d",
                 x, y, c, res, flags_out[1], br, (bf >> 1) & 1);
      end
    end
    // R6: carry ripple ignores live b (fld 10 -> n 6)
    run(3, 5, 15, 1, 10, 4'h0, 1, "R6");
    run(3, 4, 15, 1, 10, 4'h0, 1, "R6");
    // R9: AND keeps C
    run(4, 12, 10, 0, 0, 4'hE, 1, "R9");
    run(4, 12, 3, 0, 0, 4'h2, 1, "R9");
    // R10: bit test writes nothing
    run(5, 8, 8, 0, 0, 4'h6, 1, "R10");
    run(5, 8, 7, 0, 0, 4'h3, 1, "R10");
    // R11: flag clear
    run(6, 0, 5, 0, 0, 4'hF, 1, "R11");
    run(6, 0, 15, 0, 0, 4'h6, 1, "R11");
    // R12: idle and nop
    run(0, 7, 7, 1, 0, 4'h9, 0, "R12");
    run(7, 7, 7, 1, 0, 4'hA, 1, "R12");
    // mixed traffic, radix operands kept below the radix
    for (int k = 0; k < 400; k++) begin
      int o, fld, n, x, y;
      bit iss;
      o = $urandom_range(0, 7); fld = $urandom_range(0, 15); n = 16 - fld;
      iss = ($urandom_range(0, 7) != 0);
      if (o == 2 || o == 3) begin
        x = $urandom_range(0, n - 1); y = $urandom_range(0, n - 1);
      end else begin
        x = $urandom_range(0, 15); y = $urandom_range(0, 15);
      end
      run(o, x, y, $urandom_range(0, 1), fld, $urandom_range(0, 15), iss, tag_of(o, iss));
    end
    r3 = 0; f3 = 0;
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule